// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller sits beside a shadow SRAM whose every word has a nonvolatile twin. It decides when the SRAM image is copied into the nonvolatile array (a STORE) and when that array is copied back into the SRAM (a RECALL). It issues one-cycle start strobes to the array model and a busy/inhibit level that holds off host reads and writes while an operation is pending or running.

A STORE can be started in three ways:
- a power-fail flag, which signals that the supply is below the switch threshold;
- a host pulling an open-drain busy/request pin low;
- a software command pulse from an upstream address-sequence detector.

A flag records whether any SRAM write has completed since the last STORE or RECALL. The power-fail and pin-requested STOREs run only while that flag is set. A software STORE runs regardless of the flag.

After reset, and whenever the supply returns, the block runs a RECALL on its own. The RECALL first clears the SRAM and then loads it from the array. The automatic power-fail STORE can be switched off and on by command. That setting is copied into the array at each STORE and restored by each RECALL, so it outlives a power loss only if a STORE followed the change. Every duration is a parameter in clock cycles.

Top module: `nvseq_top`

## Requirements
- R1: While `rst` is high, `inhibit` is 1, `pin_drive` is 0 and no strobe is issued. On the first clock after `rst` falls with `pwr_low` = 0, a RECALL begins, and `recall_clr` is high in the next cycle.
- R2: A RECALL raises `recall_clr` in its first cycle and `recall_load` exactly CLR_CYC cycles later. It holds `pin_drive` = 1 (pin driven low) for RECALL_CYC cycles.
- R3: When `pin_in` = 0 (pin low means a request) and the write flag is set, the block waits DELAY_CYC cycles and then raises `store_go`. It holds `pin_drive` = 1 for the DELAY_CYC + STORE_CYC cycles of the operation.
- R4: When `pin_in` = 0 while the write flag is clear, no STORE runs and `pin_drive` stays 0. `inhibit` stays 1 while the pin is low.
- R5: After a pin-requested STORE completes, `inhibit` stays 1 until `pin_in` returns to 1, and falls after that.
- R6: A `sw_store` pulse accepted while idle always runs a STORE, whether or not any write has occurred. `store_go` is seen DELAY_CYC+1 clock edges after the edge that captured the pulse.
- R7: When `pwr_low` rises with the automatic STORE enabled and the write flag set, a STORE runs. With the flag clear, no STORE runs. In both cases a RECALL follows once `pwr_low` falls.
- R8: The automatic STORE is enabled after reset and is disabled by `sw_auto_off` and enabled by `sw_auto_on`. The setting is saved at each `store_go` and restored at each `recall_clr`. A change that no STORE followed is lost across a power loss.
- R9: While `pwr_low` = 1 outside an operation, `inhibit` is 1, and `sw_store` pulses and `pin_in` = 0 are ignored.
- R10: The write flag is set by `wr_done` only while idle or in the pre-STORE delay, and is cleared by `store_go` and by `recall_clr`. A write attempted during a RECALL leaves the flag clear.
- R11: A `sw_store` pulse that arrives during a RECALL is held. Its STORE runs after the RECALL ends.
- R12: `store_go` and `recall_clr` are each one cycle wide, and each fires once per operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; models power-on |
| pwr_low | input | 1 | 1 while the supply is below the switch threshold (synchronised) |
| pin_in | input | 1 | Observed level of the open-drain busy/request pin; 0 means low |
| wr_done | input | 1 | One-cycle pulse per completed host SRAM write |
| sw_store | input | 1 | Software STORE command pulse |
| sw_recall | input | 1 | Software RECALL command pulse |
| sw_auto_on | input | 1 | Command pulse enabling the automatic power-fail STORE |
| sw_auto_off | input | 1 | Command pulse disabling the automatic power-fail STORE |
| pin_drive | output | 1 | 1 drives the busy pin low |
| inhibit | output | 1 | 1 blocks host SRAM reads and writes |
| store_go | output | 1 | One-cycle STORE start strobe to the array |
| recall_clr | output | 1 | One-cycle RECALL start strobe; the array clears the SRAM |
| recall_load | output | 1 | One-cycle strobe; the array loads the SRAM from nonvolatile storage |

## Verification
The assertions assume the following about the inputs:
- `pwr_low` and `pin_in` are already synchronised to `clk`;
- each command and `wr_done` is a single-cycle pulse;
- the delay, STORE and RECALL durations are at least one cycle, and CLR_CYC is below RECALL_CYC.

The stimulus changes every input on the falling clock edge and raises pulses for exactly one cycle. It lets each STORE or RECALL finish before it applies the next trigger. It never places a write in the same cycle as a power-fail or pin request, so the write flag is always settled when the block samples a trigger.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    typedef enum logic [2:0] {
        S_PWRDN,
        S_RECALL,
        S_IDLE,
        S_DELAY,
        S_STORE,
        S_PINWAIT
    } state_e;

    typedef enum logic [1:0] {
        SRC_SW,
        SRC_PIN,
        SRC_AUTO
    } src_e;

    typedef struct packed {
        logic store_go;
        logic recall_clr;
        logic recall_load;
        logic pin_drive;
        logic busy;
        logic wr_ok;
        logic cmd_ok;
    } seq_out_s;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] cnt,
    output logic          last
);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == len - 1'b1);

endmodule

// File: rtl/nvseq_flags.sv
module nvseq_flags (
    input  logic clk,
    input  logic rst,
    input  logic wr_done,
    input  logic wr_ok,
    input  logic clr,
    input  logic cmd_ok,
    input  logic auto_on,
    input  logic auto_off,
    input  logic save,
    input  logic restore,
    output logic dirty,
    output logic auto_en
);

    logic auto_saved;

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty <= 1'b0;
        end else if (clr) begin
            dirty <= 1'b0;
        end else if (wr_done && wr_ok) begin
            dirty <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_en    <= 1'b1;
            auto_saved <= 1'b1;
        end else begin
            if (restore) begin
                auto_en <= auto_saved;
            end else if (cmd_ok && auto_off) begin
                auto_en <= 1'b0;
            end else if (cmd_ok && auto_on) begin
                auto_en <= 1'b1;
            end
            if (save) begin
                auto_saved <= auto_en;
            end
        end
    end

    // R10: a started STORE or RECALL leaves the write flag clear
    assert_clean_after_start_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !dirty);

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
    import nvseq_pkg::*;
#(
    parameter int CW        = 5,
    parameter int DELAY_CYC = 4,
    parameter int STORE_CYC = 16,
    parameter int RECALL_CYC = 12,
    parameter int CLR_CYC   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_low,
    input  logic          pin_in,
    input  logic          sw_store,
    input  logic          sw_recall,
    input  logic          dirty,
    input  logic          auto_en,
    input  logic [CW-1:0] cnt,
    input  logic          tmr_last,
    output logic          restart,
    output logic [CW-1:0] len,
    output seq_out_s      o
);

    state_e st, st_n;
    src_e   src, src_n;
    logic   pend, pend_n;

    always_comb begin
        st_n   = st;
        src_n  = src;
        pend_n = pend;
        case (st)
            S_PWRDN: begin
                if (!pwr_low) st_n = S_RECALL;
            end
            S_RECALL: begin
                if (sw_store) pend_n = 1'b1;
                if (tmr_last) begin
                    if (pwr_low) begin
                        st_n   = S_PWRDN;
                        pend_n = 1'b0;
                    end else if (pend_n) begin
                        st_n   = S_DELAY;
                        src_n  = SRC_SW;
                        pend_n = 1'b0;
                    end else begin
                        st_n = S_IDLE;
                    end
                end
            end
            S_IDLE: begin
                if (pwr_low) begin
                    st_n  = (auto_en && dirty) ? S_DELAY : S_PWRDN;
                    src_n = SRC_AUTO;
                end else if (!pin_in) begin
                    st_n  = dirty ? S_DELAY : S_PINWAIT;
                    src_n = SRC_PIN;
                end else if (sw_store) begin
                    st_n  = S_DELAY;
                    src_n = SRC_SW;
                end else if (sw_recall) begin
                    st_n = S_RECALL;
                end
            end
            S_DELAY: begin
                if (tmr_last) st_n = S_STORE;
            end
            S_STORE: begin
                if (tmr_last) begin
                    if (src == SRC_PIN && !pin_in) st_n = S_PINWAIT;
                    else if (pwr_low)              st_n = S_PWRDN;
                    else                           st_n = S_IDLE;
                end
            end
            S_PINWAIT: begin
                if (pwr_low)     st_n = S_PWRDN;
                else if (pin_in) st_n = S_IDLE;
            end
            default: st_n = S_PWRDN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_PWRDN;
            src  <= SRC_SW;
            pend <= 1'b0;
        end else begin
            st   <= st_n;
            src  <= src_n;
            pend <= pend_n;
        end
    end

    assign restart = (st_n != st);

    always_comb begin
        case (st)
            S_DELAY:  len = CW'(DELAY_CYC);
            S_STORE:  len = CW'(STORE_CYC);
            S_RECALL: len = CW'(RECALL_CYC);
            default:  len = CW'(1);
        endcase
    end

    always_comb begin
        o.store_go    = (st == S_STORE)  && (cnt == '0);
        o.recall_clr  = (st == S_RECALL) && (cnt == '0);
        o.recall_load = (st == S_RECALL) && (cnt == CW'(CLR_CYC));
        o.pin_drive   = (st == S_DELAY) || (st == S_STORE) || (st == S_RECALL);
        o.busy        = (st != S_IDLE) || pwr_low || !pin_in;
        o.wr_ok       = (st == S_IDLE) || (st == S_DELAY);
        o.cmd_ok      = (st == S_IDLE) && !pwr_low && pin_in;
    end

    // R7 / R3: power-fail and pin STOREs start only with the write flag set
    assert_dirty_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (st == S_DELAY && $past(st) == S_IDLE && src != SRC_SW) |-> $past(dirty));

    // R12: start strobes last a single cycle
    assert_store_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        o.store_go |=> !o.store_go);
    assert_recall_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        o.recall_clr |=> !o.recall_clr);

    // R3: the pin stays driven until the STORE timer runs out
    assert_drive_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (st == S_STORE && !tmr_last) |=> o.pin_drive);

    // R9: no STORE starts while waiting out a low supply
    assert_no_store_low_R9: assert property (@(posedge clk) disable iff (rst)
        (st == S_PWRDN && pwr_low) |=> !o.store_go);

endmodule

// File: rtl/nvseq_top.sv
module nvseq_top
    import nvseq_pkg::*;
#(
    parameter int DELAY_CYC  = 4,
    parameter int STORE_CYC  = 16,
    parameter int RECALL_CYC = 12,
    parameter int CLR_CYC    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_low,
    input  logic pin_in,
    input  logic wr_done,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic sw_auto_on,
    input  logic sw_auto_off,
    output logic pin_drive,
    output logic inhibit,
    output logic store_go,
    output logic recall_clr,
    output logic recall_load
);

    localparam int MAXLEN = max3(DELAY_CYC, STORE_CYC, RECALL_CYC);
    localparam int CW     = $clog2(MAXLEN + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] len;
    logic          tmr_last;
    logic          restart;
    logic          dirty;
    logic          auto_en;
    seq_out_s      so;

    nvseq_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .len     (len),
        .cnt     (cnt),
        .last    (tmr_last)
    );

    nvseq_ctrl #(
        .CW        (CW),
        .DELAY_CYC (DELAY_CYC),
        .STORE_CYC (STORE_CYC),
        .RECALL_CYC(RECALL_CYC),
        .CLR_CYC   (CLR_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pwr_low  (pwr_low),
        .pin_in   (pin_in),
        .sw_store (sw_store),
        .sw_recall(sw_recall),
        .dirty    (dirty),
        .auto_en  (auto_en),
        .cnt      (cnt),
        .tmr_last (tmr_last),
        .restart  (restart),
        .len      (len),
        .o        (so)
    );

    nvseq_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_done  (wr_done),
        .wr_ok    (so.wr_ok),
        .clr      (so.store_go | so.recall_clr),
        .cmd_ok   (so.cmd_ok),
        .auto_on  (sw_auto_on),
        .auto_off (sw_auto_off),
        .save     (so.store_go),
        .restore  (so.recall_clr),
        .dirty    (dirty),
        .auto_en  (auto_en)
    );

    assign pin_drive   = so.pin_drive;
    assign inhibit     = so.busy;
    assign store_go    = so.store_go;
    assign recall_clr  = so.recall_clr;
    assign recall_load = so.recall_load;

endmodule

// File: tb/sim_nvseq_top.sv
`timescale 1ns/100ps
module sim_nvseq_top;

    localparam int DLY = 4;
    localparam int STO = 16;
    localparam int REC = 12;
    localparam int CLR = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_low = 1'b0, pin_in = 1'b1, wr_done = 1'b0;
    logic sw_store = 1'b0, sw_recall = 1'b0, sw_auto_on = 1'b0, sw_auto_off = 1'b0;
    logic pin_drive, inhibit, store_go, recall_clr, recall_load;

    always #2.5 clk = ~clk;

    nvseq_top #(.DELAY_CYC(DLY), .STORE_CYC(STO), .RECALL_CYC(REC), .CLR_CYC(CLR)) u0 (
        .clk(clk), .rst(rst), .pwr_low(pwr_low), .pin_in(pin_in), .wr_done(wr_done),
        .sw_store(sw_store), .sw_recall(sw_recall), .sw_auto_on(sw_auto_on),
        .sw_auto_off(sw_auto_off), .pin_drive(pin_drive), .inhibit(inhibit),
        .store_go(store_go), .recall_clr(recall_clr), .recall_load(recall_load)
    );

    int cyc = 0, n_st = 0, n_clr = 0, n_ld = 0, n_drv = 0;
    int t_st = 0, t_clr = 0, t_ld = 0, t_sw = 0;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always @(posedge clk) begin
        if (!rst) begin
            cyc = cyc + 1;
            if (store_go)    begin n_st++;  t_st  = cyc; end
            if (recall_clr)  begin n_clr++; t_clr = cyc; end
            if (recall_load) begin n_ld++;  t_ld  = cyc; end
            if (pin_drive)   n_drv++;
            if (sw_store)    t_sw = cyc;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write();
        @(negedge clk) wr_done = 1'b1;
        @(negedge clk) wr_done = 1'b0;
    endtask

    task automatic pulse_store();
        @(negedge clk) sw_store = 1'b1;
        @(negedge clk) sw_store = 1'b0;
    endtask

    task automatic pulse_recall();
        @(negedge clk) sw_recall = 1'b1;
        @(negedge clk) sw_recall = 1'b0;
    endtask

    task automatic pulse_auto(bit on);
        @(negedge clk) begin sw_auto_on = on; sw_auto_off = !on; end
        @(negedge clk) begin sw_auto_on = 1'b0; sw_auto_off = 1'b0; end
    endtask

    // {trigger[1:0] (0 pin, 1 sw, 2 power-fail), write first, auto off first, store expected}
    localparam logic [4:0] VEC [8] = '{
        5'b00_1_0_1, 5'b00_0_0_0, 5'b01_0_0_1, 5'b01_1_0_1,
        5'b10_1_0_1, 5'b10_0_0_0, 5'b10_1_1_0, 5'b10_1_0_1
    };

    initial begin
        int b_st, b_drv, b_clr;
        wait_cyc(3);
        check("R1 inhibit in reset", int'(inhibit), 1);
        check("R1 pin_drive in reset", int'(pin_drive), 0);
        check("R1 store_go in reset", int'(store_go), 0);
        @(negedge clk) rst = 1'b0;
        wait_cyc(25);
        check("R1 recall start cycle", t_clr, 2);
        check("R2 recall_clr count", n_clr, 1);
        check("R2 clear-to-load gap", t_ld - t_clr, CLR);
        check("R2 recall drive length", n_drv, REC);
        check("R1 idle after recall", int'(inhibit), 0);

        for (int i = 0; i < 8; i++) begin
            logic [1:0] trig;
            logic wr, aoff, exp;
            string tag;
            {trig, wr, aoff, exp} = VEC[i];
            b_st  = n_st;
            b_drv = n_drv;
            if (aoff) pulse_auto(1'b0);
            if (wr) do_write();
            wait_cyc(2);
            case (trig)
                2'd0: begin
                    tag = exp ? "R3" : "R4";
                    @(negedge clk) pin_in = 1'b0;
                    wait_cyc(40);
                    check(exp ? "R5 held after pin store" : "R4 inhibit pin low", int'(inhibit), 1);
                    @(negedge clk) pin_in = 1'b1;
                    wait_cyc(5);
                end
                2'd1: begin
                    tag = "R6";
                    pulse_store();
                    wait_cyc(40);
                end
                default: begin
                    tag = aoff ? "R8" : "R7";
                    @(negedge clk) pwr_low = 1'b1;
                    wait_cyc(40);
                    check("R9 inhibit low supply", int'(inhibit), 1);
                    @(negedge clk) pwr_low = 1'b0;
                    wait_cyc(30);
                end
            endcase
            check(tag, n_st - b_st, int'(exp));
            check(tag, n_drv - b_drv, (exp ? DLY + STO : 0) + (trig == 2'd2 ? REC : 0));
            check(trig == 2'd0 ? "R5 release" : tag, int'(inhibit), 0);
        end

        // R6 latency and R12 single strobe
        b_st = n_st;
        pulse_store();
        wait_cyc(40);
        check("R6 latency", t_st - t_sw, DLY + 1);
        check("R12 one store strobe", n_st - b_st, 1);

        // R11 pending software STORE during RECALL
        b_st = n_st; b_clr = n_clr; b_drv = n_drv;
        pulse_recall();
        wait_cyc(3);
        pulse_store();
        wait_cyc(60);
        check("R11 pending store ran", n_st - b_st, 1);
        check("R12 one recall strobe", n_clr - b_clr, 1);
        check("R11 drive length", n_drv - b_drv, REC + DLY + STO);

        // R9 low supply ignores software store and pin request
        b_st = n_st; b_drv = n_drv;
        @(negedge clk) pwr_low = 1'b1;
        wait_cyc(3);
        pulse_store();
        @(negedge clk) pin_in = 1'b0;
        wait_cyc(2);
        check("R9 no drive on pin request", int'(pin_drive), 0);
        @(negedge clk) pin_in = 1'b1;
        wait_cyc(3);
        @(negedge clk) pwr_low = 1'b0;
        wait_cyc(40);
        check("R9 store ignored", n_st - b_st, 0);
        check("R9 only recall drive", n_drv - b_drv, REC);

        // R8 persistence of the disable through a STORE
        pulse_auto(1'b0);
        pulse_store();
        wait_cyc(40);
        b_st = n_st;
        do_write();
        @(negedge clk) pwr_low = 1'b1;
        wait_cyc(30);
        @(negedge clk) pwr_low = 1'b0;
        wait_cyc(30);
        do_write();
        @(negedge clk) pwr_low = 1'b1;
        wait_cyc(30);
        @(negedge clk) pwr_low = 1'b0;
        wait_cyc(30);
        check("R8 saved disable survives", n_st - b_st, 0);
        pulse_auto(1'b1);
        do_write();
        @(negedge clk) pwr_low = 1'b1;
        wait_cyc(40);
        @(negedge clk) pwr_low = 1'b0;
        wait_cyc(30);
        check("R8 re-enabled", n_st - b_st, 1);

        // R10 write during RECALL is not accepted
        b_st = n_st;
        pulse_recall();
        wait_cyc(2);
        do_write();
        wait_cyc(30);
        b_drv = n_drv;
        @(negedge clk) pin_in = 1'b0;
        wait_cyc(30);
        check("R10 flag clear after recall", n_st - b_st, 0);
        check("R10 no pin drive", n_drv - b_drv, 0);
        @(negedge clk) pin_in = 1'b1;
        wait_cyc(5);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule